// File: doc/BRIEF.md
# Chained Increment-Select Product Adder

This block is the last stage of a partitioned 16x16 multiplier. The multiplier compresses its partial products in two separate column groups. This block then merges the two group results into the 32-bit product. The low-group word covers product weights 19:0. The high-group word covers weights 31:16, so the two words overlap in four columns. The block is purely combinational.

The low sixteen bits pass straight through. The four overlapping columns go through a short ripple adder, whose carry starts a chain of increment-select blocks. Each block always has two candidates ready: the high-group bits as they arrive, and the same bits plus one from a converter. The carry coming up from below picks one of the two, so no carry ripples through the block itself. Block widths double going up the word. The lower block's converter also reports its own carry, which steers the next block. The top block uses a converter without a carry output, and any carry out of the top bit is lost.

Top module: `csel_final_add`

## Requirements
- R1: Product bits 15:0 equal low-word bits 15:0, whatever the high word holds.
- R2: Product bits 19:16 and the overlap carry equal the 5-bit sum of low-word bits 19:16 and high-word bits 3:0.
- R3: The block for product bits 23:20 passes a carry to the block above only when high-word bits 7:4 are all ones and the overlap carry is set. In that case, product bits 23:20 are 0000.
- R4: When the carry entering a block is clear, that block's product bits equal the matching high-word bits unchanged. For product bits 23:20 these are high-word bits 7:4; for product bits 31:24 they are high-word bits 15:8.
- R5: When the carry entering a block is set, that block's product bits equal the matching high-word bits plus one, modulo 2 to the block width. The block width is 4 for bits 23:20 and 8 for bits 31:24.
- R6: The full product equals (low word + high word * 65536) modulo 2^32.
- R7: A carry out of product bit 31 is discarded. For example, a low word of all ones with a high word of all ones gives 0x000EFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lo_i | input | 20 | Low-group result, weights 19:0 |
| hi_i | input | 16 | High-group result, weights 31:16 |
| prod_o | output | 32 | Merged product |

## Verification
The bound checker checks several properties on every input change: the low-bit pass-through, the overlap sum and its carry, the rule that a block's carry appears only for an all-ones input, the pass or increment choice made by each carry in the chain, and the full 32-bit sum. Some behaviour can only be shown by the bench's directed vectors, because it needs a specific input: a carry rippling through both blocks to a zero top, a carry that stops in the lower block, and the carry lost off bit 31.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  localparam int unsigned PASS_W_D  = 16;
  localparam int unsigned OVL_W_D   = 4;
  localparam int unsigned BASE_W_D  = 4;
  localparam int unsigned NUM_BLK_D = 2;

  // offset of block k above the overlap, widths double per block
  function automatic int unsigned blk_off(int unsigned base_w, int unsigned k);
    return base_w * ((1 << k) - 1);
  endfunction
endpackage

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] c;
  assign c[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_o[i]  = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]  = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end
  assign co_o = c[W];
endmodule

// File: rtl/inc_conv.sv
module inc_conv #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] t;
  assign t[0] = 1'b1;
  for (genvar i = 1; i < W; i++) begin : g_t
    assign t[i] = t[i-1] & b_i[i-1];
  end
  assign y_o = b_i ^ t;
endmodule

// File: rtl/inc_conv_cy.sv
module inc_conv_cy #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] b_i,
  output logic [W:0]   y_o
);
  logic [W-1:0] y;
  inc_conv #(.W(W)) u_inc (.b_i(b_i), .y_o(y));
  assign y_o = {&b_i, y};
endmodule

// File: rtl/csel_blk.sv
module csel_blk #(
  parameter int unsigned W      = 4,
  parameter bit          CY_OUT = 1'b1,
  localparam int unsigned OUT_W = W + (CY_OUT ? 1 : 0)
) (
  input  logic [W-1:0]     b_i,
  input  logic             sel_i,
  output logic [OUT_W-1:0] s_o
);
  if (CY_OUT) begin : g_cy
    logic [W:0] inc;
    inc_conv_cy #(.W(W)) u_conv (.b_i(b_i), .y_o(inc));
    assign s_o = sel_i ? inc : {1'b0, b_i};
  end else begin : g_nocy
    logic [W-1:0] inc;
    inc_conv #(.W(W)) u_conv (.b_i(b_i), .y_o(inc));
    assign s_o = sel_i ? inc : b_i;
  end
endmodule

// File: rtl/csel_final_add.sv
module csel_final_add
  import fadd_pkg::*;
#(
  parameter int unsigned PASS_W  = PASS_W_D,
  parameter int unsigned OVL_W   = OVL_W_D,
  parameter int unsigned BASE_W  = BASE_W_D,
  parameter int unsigned NUM_BLK = NUM_BLK_D,
  localparam int unsigned LO_W   = PASS_W + OVL_W,
  localparam int unsigned HI_W   = OVL_W + blk_off(BASE_W, NUM_BLK),
  localparam int unsigned P_W    = PASS_W + HI_W
) (
  input  logic [LO_W-1:0] lo_i,
  input  logic [HI_W-1:0] hi_i,
  output logic [P_W-1:0]  prod_o
);
  logic [NUM_BLK-1:0] sel_c;

  assign prod_o[PASS_W-1:0] = lo_i[PASS_W-1:0];

  ripple_add #(.W(OVL_W)) u_ovl (
    .a_i (lo_i[PASS_W +: OVL_W]),
    .b_i (hi_i[0 +: OVL_W]),
    .s_o (prod_o[PASS_W +: OVL_W]),
    .co_o(sel_c[0])
  );

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    localparam int unsigned BW  = BASE_W << k;
    localparam int unsigned OFF = OVL_W + blk_off(BASE_W, k);
    if (k < NUM_BLK - 1) begin : g_mid
      logic [BW:0] s;
      csel_blk #(.W(BW), .CY_OUT(1'b1)) u_blk (
        .b_i(hi_i[OFF +: BW]), .sel_i(sel_c[k]), .s_o(s));
      assign prod_o[PASS_W + OFF +: BW] = s[BW-1:0];
      assign sel_c[k+1] = s[BW];
    end else begin : g_top
      logic [BW-1:0] s;
      csel_blk #(.W(BW), .CY_OUT(1'b0)) u_blk (
        .b_i(hi_i[OFF +: BW]), .sel_i(sel_c[k]), .s_o(s));
      assign prod_o[PASS_W + OFF +: BW] = s;
    end
  end
endmodule

// File: rtl/csel_final_add_chk.sv
module csel_final_add_chk #(
  parameter int unsigned PASS_W  = 16,
  parameter int unsigned OVL_W   = 4,
  parameter int unsigned BASE_W  = 4,
  parameter int unsigned NUM_BLK = 2,
  localparam int unsigned LO_W   = PASS_W + OVL_W,
  localparam int unsigned HI_W   = OVL_W + BASE_W * ((1 << NUM_BLK) - 1),
  localparam int unsigned P_W    = PASS_W + HI_W
) (
  input logic [LO_W-1:0]    lo_i,
  input logic [HI_W-1:0]    hi_i,
  input logic [P_W-1:0]     prod_o,
  input logic [NUM_BLK-1:0] sel_c
);
  logic known;
  assign known = !$isunknown({lo_i, hi_i});

  always_comb begin
    if (known) begin
      assert_pass_low_R1: assert (prod_o[PASS_W-1:0] == lo_i[PASS_W-1:0]);
      assert_ovl_sum_R2: assert ({sel_c[0], prod_o[PASS_W +: OVL_W]} ==
        ({1'b0, lo_i[PASS_W +: OVL_W]} + {1'b0, hi_i[0 +: OVL_W]}));
      assert_full_sum_R6: assert (prod_o ==
        P_W'({{(P_W-LO_W){1'b0}}, lo_i} + ({{(P_W-HI_W){1'b0}}, hi_i} << PASS_W)));
    end
  end

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_k
    localparam int unsigned BW  = BASE_W << k;
    localparam int unsigned OFF = OVL_W + BASE_W * ((1 << k) - 1);
    always_comb begin
      if (known) begin
        if (!sel_c[k])
          assert_hold_R4: assert (prod_o[PASS_W + OFF +: BW] == hi_i[OFF +: BW]);
        else
          assert_incr_R5: assert (prod_o[PASS_W + OFF +: BW] == BW'(hi_i[OFF +: BW] + 1'b1));
      end
    end
    if (k < NUM_BLK - 1) begin : g_cy
      always_comb begin
        if (known && sel_c[k+1])
          assert_cy_allones_R3: assert (sel_c[k] && (&hi_i[OFF +: BW]) &&
                                        (prod_o[PASS_W + OFF +: BW] == '0));
      end
    end
  end
endmodule

bind csel_final_add csel_final_add_chk #(
  .PASS_W(PASS_W), .OVL_W(OVL_W), .BASE_W(BASE_W), .NUM_BLK(NUM_BLK)
) u_chk (
  .lo_i(lo_i), .hi_i(hi_i), .prod_o(prod_o), .sel_c(sel_c)
);

// File: tb/sim_csel_final_add.sv
module sim_csel_final_add;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [19:0] lo;
  logic [15:0] hi;
  logic [31:0] prod;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csel_final_add u0 (.lo_i(lo), .hi_i(hi), .prod_o(prod));

  function automatic logic [31:0] model(logic [19:0] l, logic [15:0] h);
    return 32'({12'd0, l} + ({16'd0, h} << 16));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (lo=%h hi=%h)", req, act, exp, lo, hi);
    end
  endtask

  task automatic apply(logic [19:0] l, logic [15:0] h);
    @(posedge clk);
    lo = l; hi = h;
    @(negedge clk);
  endtask

  task automatic t_zero();
    apply(20'h0, 16'h0);
    chk("R6", prod, 32'h0);
  endtask

  task automatic t_pass_low();
    apply(20'h0_A5C3, 16'hFFFF);
    chk("R1", {16'd0, prod[15:0]}, 32'h0000_A5C3);
    apply(20'h5_FFFF, 16'h1234);
    chk("R1", {16'd0, prod[15:0]}, 32'h0000_FFFF);
  endtask

  task automatic t_ovl();
    apply(20'h7_0000, 16'h0008);
    chk("R2", {28'd0, prod[19:16]}, 32'hF);
    chk("R4", {28'd0, prod[23:20]}, 32'h0);
    apply(20'h9_0000, 16'h0009);
    chk("R2", {28'd0, prod[19:16]}, 32'h2);
    chk("R5", {28'd0, prod[23:20]}, 32'h1);
  endtask

  task automatic t_no_carry();
    apply(20'h1_2345, 16'hABC7);
    chk("R4", {20'd0, prod[31:20]}, 32'hABC);
    chk("R6", prod, model(lo, hi));
  endtask

  task automatic t_stop_carry();
    apply(20'hF_0000, 16'h1231);
    chk("R5", {28'd0, prod[23:20]}, 32'h4);
    chk("R4", {24'd0, prod[31:24]}, 32'h12);
    apply(20'hF_0000, 16'h12F0);
    chk("R3", {24'd0, prod[31:24]}, 32'h12);
  endtask

  task automatic t_carry_chain();
    apply(20'h8_0000, 16'hFFF8);
    chk("R3", {28'd0, prod[23:20]}, 32'h0);
    chk("R5", prod, 32'h0);
    apply(20'h1_0000, 16'h3EFF);
    chk("R3", {28'd0, prod[23:20]}, 32'h0);
    chk("R5", {24'd0, prod[31:24]}, 32'h3F);
  endtask

  task automatic t_wrap_top();
    apply(20'hF_FFFF, 16'hFFFF);
    chk("R7", prod, 32'h000E_FFFF);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      apply(20'($urandom), 16'($urandom));
      chk("R6", prod, model(lo, hi));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<=20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    lo = '0; hi = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_zero();
    t_pass_low();
    t_ovl();
    t_no_carry();
    t_stop_carry();
    t_carry_chain();
    t_wrap_top();
    t_random();
    finish_run();
  end
endmodule